// File: doc/BRIEF.md
# Blocking Cache Miss and Writeback Buffer

This unit handles misses for a blocking cache. It holds one entry for an outstanding miss and one entry for an outgoing write. The cache controller offers requests on a single request port. Each request is sent to one of the two entries by its write, uncacheable and needs-response attributes and by the write-allocate setting. An entry is stored only when that entry is free. While an entry is occupied, its own blocked output is high, and the cache stalls on it.

Toward memory the unit offers one request at a time. A pending miss wins over a pending write. When the request is granted, an entry that expects no response is released at once. An entry that does expect one stays in service until memory answers. A line-fill answer only releases the miss entry. Any other answer returns the stored target tag, together with read data, to the waiting requester one cycle later. A squash for the thread that owns the miss drops its target, and it also releases the entry if the entry has not yet been issued.

Top module: `missWbBuf`

## Requirements
- R1: The address offered to memory is the stored request address with its low log2(BLK_BYTES) bits cleared.
- R2: A write goes to the writeback entry when it is uncacheable, when cfgWriteAlloc is 0, or when reqNeedsResp is 0. Every other request goes to the miss entry. memReqIsWb is 1 for the writeback entry and 0 for the miss entry.
- R3: Storing into an entry raises that entry's blocked flag (blkMiss or blkWb) and makes memReqValid high from the next cycle.
- R4: A request aimed at an entry whose blocked flag is high is ignored. The stored address and target are unchanged.
- R5: memReqFill is 1 only for a miss entry stored from a cacheable request.
- R6: When both entries are pending, the miss entry is offered first. The writeback entry is offered after the miss entry has been granted.
- R7: On memGrant the offered request is withdrawn. If it expects no response, the entry is freed and its blocked flag drops in the next cycle. Otherwise the blocked flag stays high.
- R8: A response (respValid, respIsWb selecting the entry) to an in-service line-fill frees the miss entry and returns no target.
- R9: A response to an in-service entry that is not a fill frees that entry. One cycle after the response, the unit pulses tgtValid with the stored tag. tgtData is respData for a read and 0 for a write.
- R10: A squash whose thread matches the miss entry drops its target. If the entry is not in service, the squash also frees it and withdraws its request. A squash with a non-matching thread has no effect.
- R11: wbCount increases by exactly one for each request stored in the writeback entry.
- R12: A squash in the same cycle as the miss entry's grant lets the issue proceed: the entry goes in service, and the later response frees it with no target returned.
- R13: After reset both blocked flags, memReqValid and tgtValid are 0, and wbCount is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWriteAlloc | input | 1 | Write-allocate enable |
| reqValid | input | 1 | Request offered by the cache |
| reqAddr | input | ADDR_W | Request byte address |
| reqData | input | DATA_W | Write data carried with the request |
| reqWrite | input | 1 | Request is a write |
| reqUncache | input | 1 | Request is uncacheable |
| reqNeedsResp | input | 1 | Request expects a response |
| reqThread | input | THR_W | Issuing thread |
| reqTag | input | TAG_W | Requester tag returned with the response |
| blkMiss | output | 1 | Miss entry occupied |
| blkWb | output | 1 | Writeback entry occupied |
| memReqValid | output | 1 | Request offered to memory |
| memReqIsWb | output | 1 | Offered request comes from the writeback entry |
| memReqAddr | output | ADDR_W | Block-aligned address |
| memReqData | output | DATA_W | Stored write data |
| memReqWrite | output | 1 | Offered request is a write |
| memReqFill | output | 1 | Offered request is a line fill |
| memReqNeedsResp | output | 1 | Offered request expects a response |
| memGrant | input | 1 | Memory accepts the offered request |
| respValid | input | 1 | Memory response |
| respIsWb | input | 1 | Response belongs to the writeback entry |
| respData | input | DATA_W | Response read data |
| squashValid | input | 1 | Squash request |
| squashThread | input | THR_W | Thread being squashed |
| tgtValid | output | 1 | Target return pulse |
| tgtTag | output | TAG_W | Returned requester tag |
| tgtData | output | DATA_W | Returned data |
| wbCount | output | CNT_W | Writeback event counter |

## Verification
Two functions can land on the miss entry in the same cycle: a squash for its own thread and either the memory grant or the memory response. The bench provokes both collisions. It raises squashValid together with memGrant, and separately together with respValid after issue. It then judges by the ports. After the first collision, blkMiss must stay high and memReqValid must be low. After the eventual response, blkMiss must drop and tgtValid must stay low. The remaining functions are checked by a sweep over all sixteen combinations of write, uncacheable, needs-response and write-allocate, with routing, fill, alignment and returned data computed in the bench.

// File: rtl/mwbPkg.sv
package mwbPkg;
  typedef struct packed {
    logic loadMiss;
    logic loadWb;
    logic selWb;
    logic retTarget;
    logic retFromWb;
    logic bumpWb;
  } strobeT;
endpackage

// File: rtl/mwbDatapath.sv
module mwbDatapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int THR_W = 2,
  parameter int TAG_W = 4,
  parameter int CNT_W = 8,
  parameter int BLK_BYTES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  mwbPkg::strobeT stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic reqWrite,
  input  logic reqUncache,
  input  logic reqNeedsResp,
  input  logic [THR_W-1:0] reqThread,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [DATA_W-1:0] respData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  output logic memReqWrite,
  output logic memReqFill,
  output logic memReqNeedsResp,
  output logic [THR_W-1:0] missThread,
  output logic missFill,
  output logic [TAG_W-1:0] tgtTag,
  output logic [DATA_W-1:0] tgtData,
  output logic [CNT_W-1:0] wbCount
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int N_ENT = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic write;
    logic needsResp;
    logic fill;
    logic [THR_W-1:0] thread;
    logic [TAG_W-1:0] tag;
  } entryT;

  entryT ent [N_ENT];
  logic [N_ENT-1:0] load;
  logic [ADDR_W-1:0] blkAddr;
  entryT cur;
  entryT retEnt;

  assign load = {stb.loadWb, stb.loadMiss};
  assign blkAddr = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  for (genvar i = 0; i < N_ENT; i++) begin : gEnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ent[i] <= '0;
      end else if (load[i]) begin
        ent[i].addr <= blkAddr;
        ent[i].data <= reqData;
        ent[i].write <= reqWrite;
        ent[i].needsResp <= reqNeedsResp;
        ent[i].fill <= (i == 0) && !reqUncache;
        ent[i].thread <= reqThread;
        ent[i].tag <= reqTag;
      end
    end
  end

  assign cur = ent[stb.selWb];
  assign retEnt = ent[stb.retFromWb];
  assign memReqAddr = cur.addr;
  assign memReqData = cur.data;
  assign memReqWrite = cur.write;
  assign memReqFill = cur.fill;
  assign memReqNeedsResp = cur.needsResp;
  assign missThread = ent[0].thread;
  assign missFill = ent[0].fill;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtTag <= '0;
      tgtData <= '0;
      wbCount <= '0;
    end else begin
      if (stb.retTarget) begin
        tgtTag <= retEnt.tag;
        tgtData <= retEnt.write ? '0 : respData;
      end
      if (stb.bumpWb) wbCount <= wbCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mwbControl.sv
module mwbControl #(
  parameter int THR_W = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWriteAlloc,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic reqUncache,
  input  logic reqNeedsResp,
  input  logic memGrant,
  input  logic respValid,
  input  logic respIsWb,
  input  logic squashValid,
  input  logic [THR_W-1:0] squashThread,
  input  logic [THR_W-1:0] missThread,
  input  logic missFill,
  input  logic selNeedsResp,
  output mwbPkg::strobeT stb,
  output logic blkMiss,
  output logic blkWb,
  output logic memReqValid,
  output logic memReqIsWb,
  output logic tgtValid
);
  logic [1:0] valid, inSvc, tgtOwn;
  logic [1:0] allocV, issueV, respV, freeV, squashFree, dropTgt;
  logic toWb, accMiss, accWb, pendMiss, pendWb, selWb, issue;
  logic squashHit, respOk, respFill, retTarget;

  assign toWb = reqWrite && (reqUncache || !cfgWriteAlloc || !reqNeedsResp);
  assign accMiss = reqValid && !toWb && !valid[0];
  assign accWb = reqValid && toWb && !valid[1];

  assign pendMiss = valid[0] && !inSvc[0];
  assign pendWb = valid[1] && !inSvc[1];
  assign memReqValid = pendMiss || pendWb;
  assign selWb = !pendMiss;
  assign memReqIsWb = selWb;
  assign issue = memReqValid && memGrant;

  assign squashHit = squashValid && valid[0] && (missThread == squashThread);
  assign respOk = respValid && valid[respIsWb] && inSvc[respIsWb];
  assign respFill = respOk && !respIsWb && missFill;
  assign retTarget = respOk && !respFill && tgtOwn[respIsWb] && !(!respIsWb && squashHit);

  assign allocV = {accWb, accMiss};
  assign issueV = {issue && selWb, issue && !selWb};
  assign respV = {respOk && respIsWb, respOk && !respIsWb};
  assign squashFree = {1'b0, squashHit && !inSvc[0] && !issueV[0]};
  assign dropTgt = {1'b0, squashHit};
  assign freeV = respV | (issueV & {2{!selNeedsResp}}) | squashFree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid <= '0;
      inSvc <= '0;
      tgtOwn <= '0;
      tgtValid <= 1'b0;
    end else begin
      tgtValid <= retTarget;
      for (int i = 0; i < 2; i++) begin
        if (allocV[i]) begin
          valid[i] <= 1'b1;
          inSvc[i] <= 1'b0;
          tgtOwn[i] <= reqNeedsResp;
        end else if (freeV[i]) begin
          valid[i] <= 1'b0;
          inSvc[i] <= 1'b0;
          tgtOwn[i] <= 1'b0;
        end else begin
          if (issueV[i]) inSvc[i] <= 1'b1;
          if (dropTgt[i]) tgtOwn[i] <= 1'b0;
        end
      end
    end
  end

  assign blkMiss = valid[0];
  assign blkWb = valid[1];

  always_comb begin
    stb = '0;
    stb.loadMiss = accMiss;
    stb.loadWb = accWb;
    stb.selWb = selWb;
    stb.retTarget = retTarget;
    stb.retFromWb = respIsWb;
    stb.bumpWb = accWb;
  end
endmodule

// File: rtl/missWbBuf.sv
module missWbBuf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int THR_W = 2,
  parameter int TAG_W = 4,
  parameter int CNT_W = 8,
  parameter int BLK_BYTES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWriteAlloc,
  input  logic reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic reqWrite,
  input  logic reqUncache,
  input  logic reqNeedsResp,
  input  logic [THR_W-1:0] reqThread,
  input  logic [TAG_W-1:0] reqTag,
  output logic blkMiss,
  output logic blkWb,
  output logic memReqValid,
  output logic memReqIsWb,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  output logic memReqWrite,
  output logic memReqFill,
  output logic memReqNeedsResp,
  input  logic memGrant,
  input  logic respValid,
  input  logic respIsWb,
  input  logic [DATA_W-1:0] respData,
  input  logic squashValid,
  input  logic [THR_W-1:0] squashThread,
  output logic tgtValid,
  output logic [TAG_W-1:0] tgtTag,
  output logic [DATA_W-1:0] tgtData,
  output logic [CNT_W-1:0] wbCount
);
  mwbPkg::strobeT stb;
  logic [THR_W-1:0] missThread;
  logic missFill;

  mwbControl #(.THR_W(THR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWriteAlloc(cfgWriteAlloc),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqUncache(reqUncache),
    .reqNeedsResp(reqNeedsResp), .memGrant(memGrant), .respValid(respValid),
    .respIsWb(respIsWb), .squashValid(squashValid), .squashThread(squashThread),
    .missThread(missThread), .missFill(missFill), .selNeedsResp(memReqNeedsResp),
    .stb(stb), .blkMiss(blkMiss), .blkWb(blkWb), .memReqValid(memReqValid),
    .memReqIsWb(memReqIsWb), .tgtValid(tgtValid)
  );

  mwbDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_W(THR_W), .TAG_W(TAG_W),
    .CNT_W(CNT_W), .BLK_BYTES(BLK_BYTES)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqData(reqData),
    .reqWrite(reqWrite), .reqUncache(reqUncache), .reqNeedsResp(reqNeedsResp),
    .reqThread(reqThread), .reqTag(reqTag), .respData(respData),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .memReqWrite(memReqWrite),
    .memReqFill(memReqFill), .memReqNeedsResp(memReqNeedsResp),
    .missThread(missThread), .missFill(missFill), .tgtTag(tgtTag),
    .tgtData(tgtData), .wbCount(wbCount)
  );
endmodule

// File: rtl/mwbChecker.sv
module mwbChecker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W = 8,
  parameter int BLK_BYTES = 16
) (
  input logic clk,
  input logic rstN,
  input logic memReqValid,
  input logic memReqIsWb,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic memReqFill,
  input logic memReqNeedsResp,
  input logic memGrant,
  input logic blkMiss,
  input logic blkWb,
  input logic respValid,
  input logic tgtValid,
  input logic [CNT_W-1:0] wbCount
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[OFF_W-1:0] == '0)); // R1
  AST_WB_ALLOC_REQUESTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blkWb) |-> memReqValid); // R3
  AST_FILL_ONLY_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqFill) |-> !memReqIsWb); // R5
  AST_NORESP_FREES_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memGrant && !memReqIsWb && !memReqNeedsResp) |=> !blkMiss); // R7
  AST_TARGET_AFTER_RESP: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid |-> $past(respValid)); // R9
  AST_WB_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((wbCount == $past(wbCount)) || (wbCount == $past(wbCount) + CNT_W'(1)))); // R11
endmodule

bind missWbBuf mwbChecker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLK_BYTES(BLK_BYTES)) uChk (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqIsWb(memReqIsWb),
  .memReqAddr(memReqAddr), .memReqFill(memReqFill), .memReqNeedsResp(memReqNeedsResp),
  .memGrant(memGrant), .blkMiss(blkMiss), .blkWb(blkWb), .respValid(respValid),
  .tgtValid(tgtValid), .wbCount(wbCount)
);

// File: tb/tb_missWbBuf.sv
`timescale 1ns/1ps
module tb_missWbBuf;
  localparam int ADDR_W = 16, DATA_W = 8, THR_W = 2, TAG_W = 4, CNT_W = 8, BLK_BYTES = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWriteAlloc, reqValid, reqWrite, reqUncache, reqNeedsResp;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqData, respData;
  logic [THR_W-1:0] reqThread, squashThread;
  logic [TAG_W-1:0] reqTag;
  logic memGrant, respValid, respIsWb, squashValid;
  logic blkMiss, blkWb, memReqValid, memReqIsWb, memReqWrite, memReqFill, memReqNeedsResp;
  logic [ADDR_W-1:0] memReqAddr;
  logic [DATA_W-1:0] memReqData, tgtData;
  logic tgtValid;
  logic [TAG_W-1:0] tgtTag;
  logic [CNT_W-1:0] wbCount;

  int nChecks = 0, nFail = 0;
  int expWb = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  missWbBuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_W(THR_W), .TAG_W(TAG_W),
              .CNT_W(CNT_W), .BLK_BYTES(BLK_BYTES)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; memGrant = 0; respValid = 0; squashValid = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic sendReq(logic [ADDR_W-1:0] a, logic w, logic u, logic n,
                         logic [THR_W-1:0] th, logic [TAG_W-1:0] tg, logic [DATA_W-1:0] d);
    reqValid = 1; reqAddr = a; reqWrite = w; reqUncache = u; reqNeedsResp = n;
    reqThread = th; reqTag = tg; reqData = d;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    idle();
    cfgWriteAlloc = 1; reqAddr = '0; reqData = '0; reqWrite = 0; reqUncache = 0;
    reqNeedsResp = 0; reqThread = '0; reqTag = '0; respIsWb = 0; respData = '0; squashThread = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 blkMiss", blkMiss, 0);
    check("R13 blkWb", blkWb, 0);
    check("R13 memReqValid", memReqValid, 0);
    check("R13 tgtValid", tgtValid, 0);
    check("R13 wbCount", wbCount, 0);
    rstN = 1;
    @(negedge clk);

    // Sweep: all combinations of write, uncache, needsResp, write-allocate
    for (int c = 0; c < 16; c++) begin
      logic w, u, n, wa, toWb, fill;
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] rd;
      w = c[0]; u = c[1]; n = c[2]; wa = c[3];
      toWb = w && (u || !wa || !n);
      fill = !toWb && !u;
      a = ADDR_W'(16'h1234 + c * 16'h0157);
      rd = DATA_W'(c * 7 + 3);
      cfgWriteAlloc = wa;
      sendReq(a, w, u, n, THR_W'(c), TAG_W'(c), DATA_W'(c + 8'h40));
      tick();
      if (toWb) expWb++;
      check("R2 blkWb", blkWb, toWb);
      check("R3 blkMiss", blkMiss, !toWb);
      check("R3 memReqValid", memReqValid, 1);
      check("R2 memReqIsWb", memReqIsWb, toWb);
      check("R1 memReqAddr", memReqAddr, {a[ADDR_W-1:4], 4'h0});
      check("R5 memReqFill", memReqFill, fill);
      check("R11 wbCount", wbCount, expWb);
      memGrant = 1;
      tick();
      check("R7 memReqValid", memReqValid, 0);
      check("R7 blocked", blkMiss | blkWb, n);
      if (n) begin
        respValid = 1; respIsWb = toWb; respData = rd;
        tick();
        check("R8 R9 freed", blkMiss | blkWb, 0);
        check("R8 R9 tgtValid", tgtValid, !fill);
        if (!fill) begin
          check("R9 tgtTag", tgtTag, c);
          check("R9 tgtData", tgtData, w ? 0 : rd);
        end
      end
      tick();
      check("R9 tgtValid one pulse", tgtValid, 0);
    end
    cfgWriteAlloc = 1;

    // R6 priority and R4 ignore-while-blocked
    sendReq(16'h0a0f, 1, 1, 0, 0, 1, 8'h11); tick(); expWb++;
    sendReq(16'h0b2c, 0, 0, 1, 0, 2, 8'h00); tick();
    check("R6 miss first", memReqIsWb, 0);
    check("R6 miss addr", memReqAddr, 16'h0b20);
    sendReq(16'h0c33, 0, 0, 1, 0, 3, 8'h00); tick();
    check("R4 addr kept", memReqAddr, 16'h0b20);
    sendReq(16'h0dd1, 1, 1, 0, 0, 4, 8'h99); tick();
    check("R4 wb count kept", wbCount, expWb);
    memGrant = 1; tick();
    check("R6 wb next", memReqIsWb, 1);
    check("R4 wb data kept", memReqData, 8'h11);
    memGrant = 1; tick();
    check("R7 wb freed", blkWb, 0);
    respValid = 1; respIsWb = 0; tick();
    check("R8 fill freed", blkMiss, 0);
    check("R8 no target", tgtValid, 0);

    // R10 squash of pending miss
    sendReq(16'h2200, 0, 1, 1, 1, 5, 8'h00); tick();
    squashValid = 1; squashThread = 2; tick();
    check("R10 mismatch blkMiss", blkMiss, 1);
    check("R10 mismatch memReqValid", memReqValid, 1);
    squashValid = 1; squashThread = 1; tick();
    check("R10 pending freed", blkMiss, 0);
    check("R10 request withdrawn", memReqValid, 0);

    // R10 squash of in-service miss, same cycle as response
    sendReq(16'h3300, 0, 1, 1, 3, 6, 8'h00); tick();
    memGrant = 1; tick();
    respValid = 1; respIsWb = 0; respData = 8'h5a; squashValid = 1; squashThread = 3; tick();
    check("R10 resp+squash freed", blkMiss, 0);
    check("R10 resp+squash no target", tgtValid, 0);

    // R10 squash in service then later response
    sendReq(16'h3400, 0, 1, 1, 3, 6, 8'h00); tick();
    memGrant = 1; tick();
    squashValid = 1; squashThread = 3; tick();
    check("R10 in-service kept", blkMiss, 1);
    respValid = 1; respIsWb = 0; tick();
    check("R10 later resp freed", blkMiss, 0);
    check("R10 later resp no target", tgtValid, 0);

    // R12 squash in the same cycle as grant
    sendReq(16'h4400, 0, 1, 1, 2, 7, 8'h00); tick();
    memGrant = 1; squashValid = 1; squashThread = 2; tick();
    check("R12 still blocked", blkMiss, 1);
    check("R12 issued", memReqValid, 0);
    respValid = 1; respIsWb = 0; respData = 8'h77; tick();
    check("R12 freed", blkMiss, 0);
    check("R12 no target", tgtValid, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule